// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block watches the first six bytes of every received frame, which carry the destination address, and decides whether the frame is wanted. It can accept a frame on any of six paths, each with its own enable:
- exact match against a programmed station address;
- any unicast frame;
- any broadcast frame;
- any multicast frame;
- a unicast frame that hits a 64-bin hash table;
- a multicast frame that hits the same 64-bin hash table.

The hash bin comes from a CRC-32 computed over the six destination bytes only.

The block also keeps a sticky wake-up status. It records which accept paths fired when filter wake-up is enabled. It also records a magic-packet indication that some other logic supplies. Software clears the status bits by writing ones to a clear input.

The result arrives as a one-cycle valid pulse together with the accept flag and classification flags. These flags stay unchanged until the next result. Frame CRC checking and the rest of the receive path sit outside this block.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, result_vld, accept, dst_bcast, dst_mcast, perfect_hit, hash_hit and every wol_status bit are 0.
- R2: A byte with byte_vld and sof high is destination byte 0, and the next five valid bytes are bytes 1 to 5. result_vld is high for exactly one cycle, the cycle after byte 5. Valid bytes after byte 5 that lack sof are ignored. A new sof before byte 5 restarts the count at byte 0.
- R3: The hash index is bits 28..23 of a CRC-32 over bytes 0..5. The CRC uses polynomial 0x04C11DB7 and starts from all ones. Each byte is fed least significant bit first, which is the same as two 4-bit steps, low nibble first, each shifting left by 4. Index 32..63 selects bit (index-32) of hash_hi, and index 0..31 selects bit index of hash_lo. hash_hit reports the selected bit.
- R4: The destination is multicast when bit 0 of byte 0 is 1. It is broadcast when all 48 bits are 1. dst_bcast reports broadcast. dst_mcast reports multicast that is not broadcast.
- R5: perfect_hit is 1 when the bytes equal the station address. stn_w0 holds {byte 5, byte 4}, stn_w1 holds {byte 3, byte 2} and stn_w2 holds {byte 1, byte 0}, with the higher-numbered byte in bits 15..8.
- R6: accept is the OR of six enabled paths, each enable bit in flt_ctrl:
  - bit0: any non-multicast frame;
  - bit1: broadcast;
  - bit2: multicast that is not broadcast;
  - bit3: unicast hash;
  - bit4: multicast hash;
  - bit5: perfect match.
- R7: The flt_ctrl bit3 path fires only for non-multicast frames with hash_hit. The flt_ctrl bit4 path fires only for multicast, non-broadcast frames with hash_hit.
- R8: When flt_ctrl bit7 is 1 and a frame is accepted, the result cycle sets wol_status bit n for each firing path n (0..5) and also sets wol_status bit 6.
- R9: magic_det high in a cycle with flt_ctrl bit6 = 1 sets wol_status bit 7 on that edge. With bit6 = 0 it has no effect.
- R10: Each wol_status bit stays set until a cycle where the same wol_clr bit is 1. If a set and a clear hit the same bit in the same cycle, the set wins.
- R11: accept and the classification outputs keep their values between results, including while a new frame's bytes arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | byte_data carries a received byte |
| sof | input | 1 | Marks the first byte of a frame (with byte_vld) |
| byte_data | input | 8 | Received byte |
| stn_w0 | input | 16 | Station address bytes 5 and 4 |
| stn_w1 | input | 16 | Station address bytes 3 and 2 |
| stn_w2 | input | 16 | Station address bytes 1 and 0 |
| hash_lo | input | 32 | Hash table bins 0..31 |
| hash_hi | input | 32 | Hash table bins 32..63 |
| flt_ctrl | input | 8 | Path enables (bits 5..0), magic wake enable (6), filter wake enable (7) |
| magic_det | input | 1 | Magic packet seen (one-cycle pulse) |
| wol_clr | input | 8 | Write-one-to-clear strobe for wol_status |
| result_vld | output | 1 | One-cycle pulse: verdict updated |
| accept | output | 1 | Frame accepted |
| dst_bcast | output | 1 | Destination is broadcast |
| dst_mcast | output | 1 | Destination is multicast, not broadcast |
| perfect_hit | output | 1 | Destination equals station address |
| hash_hit | output | 1 | Selected hash bin is set |
| wol_status | output | 8 | Sticky wake-up cause bits |

## Verification
A corrupted byte counter shows on the first frame that follows it: result_vld appears a cycle early or late, or twice. A byte stored in the wrong address slot shows in the next verdict as a wrong perfect_hit. A CRC register that carries state across sof shows as a hash_hit that disagrees with the bin the bench computes for the same six bytes. Wake-up status errors persist because the bits are sticky, so one wrong set or clear stays visible on wol_status until the next clear strobe. The bench compares every output against its model on every clock, so any of these faults is reported within one cycle of reaching the ports.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  localparam int unsigned ADDR_BYTES   = 6;
  localparam int unsigned ADDR_W       = 8 * ADDR_BYTES;
  localparam int unsigned CRC_W        = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam int unsigned NIB_PER_BYTE = 2;
  localparam int unsigned HASH_W       = 6;
  localparam int unsigned HASH_LSB     = 23;
  localparam int unsigned NPATH        = 6;

  // flt_ctrl bit positions
  localparam int unsigned EN_UCAST     = 0;
  localparam int unsigned EN_BCAST     = 1;
  localparam int unsigned EN_MCAST     = 2;
  localparam int unsigned EN_UHASH     = 3;
  localparam int unsigned EN_MHASH     = 4;
  localparam int unsigned EN_PERFECT   = 5;
  localparam int unsigned EN_WAKE_MAG  = 6;
  localparam int unsigned EN_WAKE_FILT = 7;

  // wol_status bit positions beyond the per-path bits
  localparam int unsigned ST_RXFILT    = 6;
  localparam int unsigned ST_MAGIC     = 7;

  typedef struct packed {
    logic             bcast;
    logic             mcast;
    logic             perfect;
    logic             hash;
    logic [NPATH-1:0] paths;
  } rxaf_verdict_t;

  // One 4-bit CRC step; nibble bit 0 is the first bit on the wire.
  function automatic logic [CRC_W-1:0] crc_nibble_step(input logic [CRC_W-1:0] c,
                                                        input logic [3:0]       nib);
    logic [CRC_W-1:0] r;
    r = c << 4;
    for (int k = 0; k < 4; k++) begin
      if (c[CRC_W-1-k] ^ nib[k]) r = r ^ (CRC_POLY << (3 - k));
    end
    return r;
  endfunction

endpackage

// File: rtl/rxaf_dest_capture.sv
module rxaf_dest_capture
  import rxaf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              sof,
  input  logic [7:0]        byte_data,
  output logic              take,
  output logic              last,
  output logic [ADDR_W-1:0] addr_full
);

  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d, idx;
  logic [ADDR_W-1:0] addr_q;
  logic              in_frame;

  always_comb begin
    in_frame = (cnt_q < CNT_W'(ADDR_BYTES));
    take     = byte_vld & (sof | in_frame);
    idx      = sof ? '0 : cnt_q;
    last     = take & (idx == CNT_W'(ADDR_BYTES - 1));
    cnt_d    = take ? idx + 1'b1 : cnt_q;
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
    assign addr_full[8*g +: 8] = (take && (idx == CNT_W'(g))) ? byte_data : addr_q[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(ADDR_BYTES);
      addr_q <= '0;
    end else if (take) begin
      cnt_q  <= cnt_d;
      addr_q <= addr_full;
    end
  end

endmodule

// File: rtl/rxaf_crc_unit.sv
module rxaf_crc_unit
  import rxaf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              restart,
  input  logic [7:0]        byte_data,
  output logic [HASH_W-1:0] hash_idx
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] chain [NIB_PER_BYTE+1];

  assign chain[0] = restart ? '1 : crc_q;

  for (genvar g = 0; g < NIB_PER_BYTE; g++) begin : g_nib
    assign chain[g+1] = crc_nibble_step(chain[g], byte_data[4*g +: 4]);
  end

  assign hash_idx = chain[NIB_PER_BYTE][HASH_LSB +: HASH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else if (take) crc_q <= chain[NIB_PER_BYTE];
  end

endmodule

// File: rtl/rxaf_match.sv
module rxaf_match
  import rxaf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [HASH_W-1:0] hash_idx,
  input  logic [15:0]       stn_w0,
  input  logic [15:0]       stn_w1,
  input  logic [15:0]       stn_w2,
  input  logic [31:0]       hash_lo,
  input  logic [31:0]       hash_hi,
  input  logic [NPATH-1:0]  en,
  output rxaf_verdict_t     verdict
);

  logic [ADDR_W-1:0]       station;
  logic [2**HASH_W-1:0]    table_bits;
  logic                    mc, bc, grp, hbit, pm;

  always_comb begin
    station    = {stn_w0, stn_w1, stn_w2};
    table_bits = {hash_hi, hash_lo};
    mc         = addr[0];
    bc         = &addr;
    grp        = mc & ~bc;
    hbit       = table_bits[hash_idx];
    pm         = (addr == station);

    verdict.bcast   = bc;
    verdict.mcast   = grp;
    verdict.perfect = pm;
    verdict.hash    = hbit;
    verdict.paths[EN_UCAST]   = en[EN_UCAST]   & ~mc;
    verdict.paths[EN_BCAST]   = en[EN_BCAST]   & bc;
    verdict.paths[EN_MCAST]   = en[EN_MCAST]   & grp;
    verdict.paths[EN_UHASH]   = en[EN_UHASH]   & ~mc & hbit;
    verdict.paths[EN_MHASH]   = en[EN_MHASH]   & grp & hbit;
    verdict.paths[EN_PERFECT] = en[EN_PERFECT] & pm;
  end

endmodule

// File: rtl/rxaf_wol.sv
module rxaf_wol
  import rxaf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval,
  input  logic [NPATH-1:0] paths,
  input  logic             wake_filt_en,
  input  logic             wake_mag_en,
  input  logic             magic_det,
  input  logic [7:0]       clr,
  output logic [7:0]       status
);

  logic [7:0] status_q, status_d, set_v;
  logic       filt_fire;

  always_comb begin
    filt_fire            = eval & wake_filt_en & (|paths);
    set_v                = '0;
    set_v[NPATH-1:0]     = filt_fire ? paths : '0;
    set_v[ST_RXFILT]     = filt_fire;
    set_v[ST_MAGIC]      = magic_det & wake_mag_en;
    status_d             = (status_q & ~clr) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status = status_q;

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic        sof,
  input  logic [7:0]  byte_data,
  input  logic [15:0] stn_w0,
  input  logic [15:0] stn_w1,
  input  logic [15:0] stn_w2,
  input  logic [31:0] hash_lo,
  input  logic [31:0] hash_hi,
  input  logic [7:0]  flt_ctrl,
  input  logic        magic_det,
  input  logic [7:0]  wol_clr,
  output logic        result_vld,
  output logic        accept,
  output logic        dst_bcast,
  output logic        dst_mcast,
  output logic        perfect_hit,
  output logic        hash_hit,
  output logic [7:0]  wol_status
);

  logic              take, last;
  logic [ADDR_W-1:0] addr_full;
  logic [HASH_W-1:0] hash_idx;
  rxaf_verdict_t     verdict, vd_q;
  logic              vld_q;

  rxaf_dest_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .sof       (sof),
    .byte_data (byte_data),
    .take      (take),
    .last      (last),
    .addr_full (addr_full)
  );

  rxaf_crc_unit u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .restart   (sof),
    .byte_data (byte_data),
    .hash_idx  (hash_idx)
  );

  rxaf_match u_match (
    .addr     (addr_full),
    .hash_idx (hash_idx),
    .stn_w0   (stn_w0),
    .stn_w1   (stn_w1),
    .stn_w2   (stn_w2),
    .hash_lo  (hash_lo),
    .hash_hi  (hash_hi),
    .en       (flt_ctrl[NPATH-1:0]),
    .verdict  (verdict)
  );

  rxaf_wol u_wol (
    .clk          (clk),
    .rst_n        (rst_n),
    .eval         (last),
    .paths        (verdict.paths),
    .wake_filt_en (flt_ctrl[EN_WAKE_FILT]),
    .wake_mag_en  (flt_ctrl[EN_WAKE_MAG]),
    .magic_det    (magic_det),
    .clr          (wol_clr),
    .status       (wol_status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vd_q <= '0;
    else if (last) vd_q <= verdict;
  end

  assign result_vld  = vld_q;
  assign accept      = |vd_q.paths;
  assign dst_bcast   = vd_q.bcast;
  assign dst_mcast   = vd_q.mcast;
  assign perfect_hit = vd_q.perfect;
  assign hash_hit    = vd_q.hash;

endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       result_vld,
  input logic       accept,
  input logic       dst_bcast,
  input logic       dst_mcast,
  input logic [7:0] wol_status,
  input logic [7:0] wol_clr,
  input logic       wake_mag_en,
  input logic       magic_det
);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |=> !result_vld);

  assert_class_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dst_bcast |-> !dst_mcast);

  assert_accept_rises_with_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept) |-> result_vld);

  assert_hold_between_results_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !result_vld |-> ($stable(accept) && $stable(dst_bcast) && $stable(dst_mcast)));

  assert_magic_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (magic_det && wake_mag_en) |=> wol_status[7]);

  assert_sticky_until_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(wol_status) & ~wol_status)) |-> (|($past(wol_status) & $past(wol_clr))));

endmodule

bind rx_addr_filter rxaf_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .result_vld  (result_vld),
  .accept      (accept),
  .dst_bcast   (dst_bcast),
  .dst_mcast   (dst_mcast),
  .wol_status  (wol_status),
  .wol_clr     (wol_clr),
  .wake_mag_en (flt_ctrl[6]),
  .magic_det   (magic_det)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, byte_vld, sof, magic_det;
  logic [7:0]  byte_data, flt_ctrl, wol_clr;
  logic [15:0] stn_w0, stn_w1, stn_w2;
  logic [31:0] hash_lo, hash_hi;
  logic        result_vld, accept, dst_bcast, dst_mcast, perfect_hit, hash_hit;
  logic [7:0]  wol_status;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  rx_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .byte_data(byte_data),
    .stn_w0(stn_w0), .stn_w1(stn_w1), .stn_w2(stn_w2),
    .hash_lo(hash_lo), .hash_hi(hash_hi), .flt_ctrl(flt_ctrl),
    .magic_det(magic_det), .wol_clr(wol_clr),
    .result_vld(result_vld), .accept(accept), .dst_bcast(dst_bcast), .dst_mcast(dst_mcast),
    .perfect_hit(perfect_hit), .hash_hit(hash_hit), .wol_status(wol_status)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Serial CRC-32, one bit per step, byte LSB first.
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ b[i];
      c  = c << 1;
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  function automatic int bin_of(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++) c = crc_byte(c, a[8*k +: 8]);
    return int'(c[28:23]);
  endfunction

  // ---------------- reference model ----------------
  int          m_cnt;
  logic [7:0]  m_ab [6];
  logic [31:0] m_crc;
  logic        e_vld, e_acc, e_bc, e_mc, e_ph, e_hh;
  logic [7:0]  e_wol;

  always @(posedge clk) begin
    logic [7:0] setv;
    logic [5:0] p;
    logic mc, bc, pm, hb;
    int ix;
    if (!rst_n) begin
      m_cnt = 6; e_vld = 0; e_acc = 0; e_bc = 0; e_mc = 0; e_ph = 0; e_hh = 0; e_wol = 0;
    end else begin
      setv  = 0;
      e_vld = 0;
      if (byte_vld && (sof || m_cnt < 6)) begin
        if (sof) begin m_cnt = 0; m_crc = 32'hFFFFFFFF; end
        m_ab[m_cnt] = byte_data;
        m_crc = crc_byte(m_crc, byte_data);
        m_cnt++;
        if (m_cnt == 6) begin
          mc = m_ab[0][0];
          bc = 1;
          for (int k = 0; k < 6; k++) if (m_ab[k] != 8'hFF) bc = 0;
          ix = int'(m_crc[28:23]);
          hb = (ix >= 32) ? hash_hi[ix-32] : hash_lo[ix];
          pm = (m_ab[5] == stn_w0[15:8]) && (m_ab[4] == stn_w0[7:0]) &&
               (m_ab[3] == stn_w1[15:8]) && (m_ab[2] == stn_w1[7:0]) &&
               (m_ab[1] == stn_w2[15:8]) && (m_ab[0] == stn_w2[7:0]);
          p[0] = flt_ctrl[0] && !mc;
          p[1] = flt_ctrl[1] && bc;
          p[2] = flt_ctrl[2] && mc && !bc;
          p[3] = flt_ctrl[3] && !mc && hb;
          p[4] = flt_ctrl[4] && mc && !bc && hb;
          p[5] = flt_ctrl[5] && pm;
          e_vld = 1; e_acc = |p; e_bc = bc; e_mc = mc && !bc; e_ph = pm; e_hh = hb;
          if (flt_ctrl[7] && (|p)) setv = {2'b01, p};
        end
      end
      if (magic_det && flt_ctrl[6]) setv[7] = 1'b1;
      e_wol = (e_wol & ~wol_clr) | setv;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "result_vld", result_vld, e_vld);
      chk("R6", "accept", accept, e_acc);
      chk("R4", "dst_bcast", dst_bcast, e_bc);
      chk("R4", "dst_mcast", dst_mcast, e_mc);
      chk("R5", "perfect_hit", perfect_hit, e_ph);
      chk("R3", "hash_hit", hash_hit, e_hh);
      chk("R8", "wol_status", wol_status, e_wol);
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [47:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      byte_vld  = 1'b1;
      sof       = (k == 0);
      byte_data = (k < 6) ? a[8*k +: 8] : 8'hA5;
    end
    @(negedge clk);
    byte_vld = 1'b0;
    sof      = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [47:0] STN  = 48'h665544332210;
  localparam logic [47:0] UNI  = 48'h000012345678;
  localparam logic [47:0] MUL  = 48'h5E0000AB0001;
  localparam logic [47:0] BCST = 48'hFFFFFFFFFFFF;

  initial begin
    int ix;
    rst_n = 0; byte_vld = 0; sof = 0; byte_data = 0; magic_det = 0; wol_clr = 0;
    stn_w0 = STN[47:32]; stn_w1 = STN[31:16]; stn_w2 = STN[15:0];
    hash_lo = 0; hash_hi = 0; flt_ctrl = 0;
    idle(3);
    chk("R1", "result_vld", result_vld, 0);
    chk("R1", "accept", accept, 0);
    chk("R1", "class", {dst_bcast, dst_mcast, perfect_hit, hash_hit}, 0);
    chk("R1", "wol_status", wol_status, 0);
    rst_n = 1;
    idle(2);

    // R5 perfect match and byte ordering
    flt_ctrl = 8'h20;
    send(STN, 6);
    chk("R5", "perfect accept", {accept, perfect_hit, result_vld}, 3'b111);
    send(STN ^ 48'h010000000000, 6);
    chk("R5", "byte5 differs", {accept, perfect_hit}, 2'b00);
    send({STN[15:0], STN[47:16]}, 6);
    chk("R5", "rotated address", perfect_hit, 0);

    // R4 / R6 broadcast and multicast paths
    flt_ctrl = 8'h02;
    send(BCST, 6);
    chk("R4", "bcast class", {accept, dst_bcast, dst_mcast}, 3'b110);
    send(MUL, 6);
    chk("R6", "mcast without enable", {accept, dst_mcast}, 2'b01);
    flt_ctrl = 8'h04;
    send(MUL, 6);
    chk("R6", "mcast enabled", accept, 1);
    send(BCST, 6);
    chk("R6", "bcast not via mcast path", accept, 0);
    flt_ctrl = 8'h01;
    send(UNI, 6);
    chk("R6", "unicast enabled", accept, 1);
    send(MUL, 6);
    chk("R6", "unicast path rejects mcast", accept, 0);

    // R3 hash bin selection, both halves
    flt_ctrl = 0;
    for (int t = 0; t < 8; t++) begin
      logic [47:0] a;
      a = {16'h1000 + 16'(t * 16'h0911), 32'h00C0FFEE ^ 32'(t * 32'h01234567)};
      ix = bin_of(a);
      hash_lo = '1; hash_hi = '0;
      send(a, 6);
      chk("R3", "low table word", hash_hit, (ix < 32));
      hash_lo = '0; hash_hi = '1;
      send(a, 6);
      chk("R3", "high table word", hash_hit, (ix >= 32));
    end

    // R7 hash paths restricted by class
    ix = bin_of(UNI);
    {hash_hi, hash_lo} = 64'd1 << ix;
    flt_ctrl = 8'h10;
    send(UNI, 6);
    chk("R7", "mhash ignores unicast", {accept, hash_hit}, 2'b01);
    flt_ctrl = 8'h08;
    send(UNI, 6);
    chk("R7", "uhash accepts unicast", accept, 1);
    ix = bin_of(MUL);
    {hash_hi, hash_lo} = 64'd1 << ix;
    send(MUL, 6);
    chk("R7", "uhash ignores mcast", {accept, hash_hit}, 2'b01);
    flt_ctrl = 8'h10;
    send(MUL, 6);
    chk("R7", "mhash accepts mcast", accept, 1);
    ix = bin_of(BCST);
    {hash_hi, hash_lo} = 64'd1 << ix;
    send(BCST, 6);
    chk("R7", "mhash ignores bcast", {accept, hash_hit}, 2'b01);

    // R2 restart on sof, extra bytes ignored; R11 hold
    flt_ctrl = 8'h20;
    send(STN, 3);
    chk("R2", "no result on partial", result_vld, 0);
    send(STN, 6);
    chk("R2", "result after restart", {result_vld, accept}, 2'b11);
    send(UNI, 9);
    chk("R2", "single pulse with extra bytes", result_vld, 0);
    chk("R11", "verdict of 9-byte frame", accept, 0);
    send(STN, 6);
    idle(4);
    chk("R11", "held while idle", {accept, perfect_hit}, 2'b11);
    send(UNI, 4);
    chk("R11", "held during partial frame", {accept, perfect_hit}, 2'b11);

    // R8 filter wake-up
    flt_ctrl = 8'hA0;
    send(STN, 6);
    chk("R8", "wake bits", wol_status, 8'h60);
    flt_ctrl = 8'h20;
    send(STN, 6);
    chk("R8", "no wake when disabled", wol_status, 8'h60);

    // R10 clear
    @(negedge clk); wol_clr = 8'h20;
    @(negedge clk); wol_clr = 8'h00;
    chk("R10", "partial clear", wol_status, 8'h40);

    // R9 magic
    flt_ctrl = 8'h00;
    @(negedge clk); magic_det = 1;
    @(negedge clk); magic_det = 0;
    chk("R9", "magic ignored", wol_status, 8'h40);
    flt_ctrl = 8'h40;
    @(negedge clk); magic_det = 1; wol_clr = 8'hFF;
    @(negedge clk); magic_det = 0; wol_clr = 8'h00;
    chk("R10", "set wins over clear", wol_status, 8'h80);
    chk("R9", "magic sets bit7", wol_status[7], 1);
    @(negedge clk); wol_clr = 8'h80;
    @(negedge clk); wol_clr = 8'h00;
    chk("R10", "full clear", wol_status, 8'h00);

    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule